// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sets how a small processor is clocked and how it sleeps. A register write port picks one of six CPU clock rates, marks which peripherals receive a clock, and commands the move from running into one of two sleep states. The CPU clock is given as a clock-enable pulse train at the selected divide ratio. Each peripheral clock is a separate level enable, independent of the CPU rate.

The light sleep state (HALT) keeps the oscillator running and gates off a chosen subset of peripheral clocks. Any interrupt, internal or external, resumes RUN on the next cycle. The deep sleep state (STANDBY) stops the oscillator and all clocks. Only the external interrupt ends it. The block then passes through a settling state in which the oscillator runs but the CPU clock stays off until a programmed number of reference ticks has elapsed. A mode command written during that settling is kept and carried out as soon as RUN is reached. The current mode and the source of the last wake-up are available as output fields.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is RUN (code 0), the wake source is none (code 0), the oscillator runs, the CPU clock-enable is high on every cycle (divide by 1), and every peripheral clock enable is on.
- R2: Writing code c (0 to 5) to the rate field (address 0, bits 2:0) makes the CPU clock-enable pulse once every 2^c cycles in RUN, so 64>>c pulses per 64 cycles.
- R3: A rate code of 6 or 7 is ignored, and the previous divide ratio stays in force.
- R4: In RUN each peripheral clock enable equals its bit in the peripheral mask (address 1), whatever the CPU rate.
- R5: A mode command (address 4, bits 1:0) of 1 enters HALT (mode code 1). There the CPU clock-enable is low, the oscillator runs, and the peripheral enables equal the mask with the bits set in the halt gate mask (address 2) cleared.
- R6: In HALT any internal interrupt bit or the external interrupt returns the mode to RUN on the next cycle. The wake source becomes external (code 1) if the external input was high, otherwise internal (code 2).
- R7: A mode command of 2 enters STANDBY (mode code 2). There the oscillator, the CPU clock-enable and all peripheral enables are off, and internal interrupts have no effect.
- R8: The external interrupt moves STANDBY to the settling mode (code 3) with wake source external. The CPU clock-enable stays low until the count at address 3 of reference ticks has passed, and then the mode returns to RUN.
- R9: A settling count of zero behaves as a count of one.
- R10: A HALT or STANDBY command written during settling leaves the mode in settling. It is carried out on the cycle after RUN is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| ext_irq | input | 1 | External interrupt |
| int_irq | input | NUM_INT | Internal interrupt vector |
| ref_tick | input | 1 | Stable-clock reference tick used during settling |
| cpu_clk_en | output | 1 | Divided CPU clock-enable pulse train |
| per_clk_en | output | NUM_PER | Per-peripheral clock enables |
| osc_run | output | 1 | Oscillator run request |
| mode_o | output | 2 | Current mode: 0 RUN, 1 HALT, 2 STANDBY, 3 settling |
| wake_src_o | output | 2 | Last wake source: 0 none, 1 external, 2 internal |

## Verification
The hardest case to reach is a mode command that arrives while the block is settling after STANDBY. It can only happen in a narrow window that opens with an external interrupt and closes with the last reference tick. The bench drives the reference tick by hand. It shortens the settling count to two, wakes the block, writes a HALT command before issuing any tick, and checks that the mode is still settling. It then releases the ticks and checks that HALT is entered right after RUN is reached.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_HALT = 2'd1,
    M_STBY = 2'd2,
    M_WAKE = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_EXT  = 2'd1,
    W_INT  = 2'd2
  } wsrc_e;

  localparam logic [2:0] A_RATE  = 3'd0;
  localparam logic [2:0] A_PERM  = 3'd1;
  localparam logic [2:0] A_GATE  = 3'd2;
  localparam logic [2:0] A_SETL  = 3'd3;
  localparam logic [2:0] A_MODE  = 3'd4;

  localparam logic [1:0] CMD_HALT = 2'd1;
  localparam logic [1:0] CMD_STBY = 2'd2;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_PER   = 4,
  parameter int CNT_W     = 16,
  parameter int CODE_W    = 3,
  parameter int NUM_RATES = 6,
  parameter int SETL_RST  = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [CODE_W-1:0]  rate_code,
  output logic               rate_load,
  output logic [NUM_PER-1:0] per_mask,
  output logic [NUM_PER-1:0] gate_mask,
  output logic [CNT_W-1:0]   setl_cnt,
  output logic               cmd_vld,
  output logic [1:0]         cmd_val
);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_RATES - 1);

  logic [CODE_W-1:0] new_code;

  assign new_code  = wr_data[CODE_W-1:0];
  assign rate_load = wr_en && (wr_addr == A_RATE) && (new_code <= LAST_CODE);
  assign cmd_vld   = wr_en && (wr_addr == A_MODE);
  assign cmd_val   = wr_data[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_code <= '0;
      per_mask  <= '1;
      gate_mask <= '1;
      setl_cnt  <= CNT_W'(SETL_RST);
    end else begin
      if (rate_load) rate_code <= new_code;
      if (wr_en && wr_addr == A_PERM) per_mask  <= wr_data[NUM_PER-1:0];
      if (wr_en && wr_addr == A_GATE) gate_mask <= wr_data[NUM_PER-1:0];
      if (wr_en && wr_addr == A_SETL) setl_cnt  <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_irq,
  input  logic [NUM_INT-1:0] int_irq,
  input  logic               ref_tick,
  input  logic               cmd_vld,
  input  logic [1:0]         cmd_val,
  input  logic [CNT_W-1:0]   setl_cnt,
  output pmode_e             mode_d,
  output pmode_e             mode_q,
  output wsrc_e              wsrc_q
);
  wsrc_e            wsrc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  pmode_e           pmode_q, pmode_d;
  logic             cmd_sleep;

  assign cmd_sleep = cmd_vld && (cmd_val == CMD_HALT || cmd_val == CMD_STBY);

  always_comb begin
    mode_d  = mode_q;
    wsrc_d  = wsrc_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    pmode_d = pmode_q;
    unique case (mode_q)
      M_RUN: begin
        if (pend_q) begin
          mode_d = pmode_q;
          pend_d = 1'b0;
        end else if (cmd_vld && cmd_val == CMD_HALT) begin
          mode_d = M_HALT;
        end else if (cmd_vld && cmd_val == CMD_STBY) begin
          mode_d = M_STBY;
        end
      end
      M_HALT: begin
        if (ext_irq) begin
          mode_d = M_RUN;
          wsrc_d = W_EXT;
        end else if (|int_irq) begin
          mode_d = M_RUN;
          wsrc_d = W_INT;
        end
      end
      M_STBY: begin
        if (ext_irq) begin
          mode_d = M_WAKE;
          wsrc_d = W_EXT;
          cnt_d  = (setl_cnt == '0) ? CNT_W'(1) : setl_cnt;
        end
      end
      M_WAKE: begin
        if (cmd_sleep) begin
          pend_d  = 1'b1;
          pmode_d = (cmd_val == CMD_HALT) ? M_HALT : M_STBY;
        end
        if (ref_tick) begin
          if (cnt_q <= CNT_W'(1)) mode_d = M_RUN;
          else                    cnt_d  = cnt_q - CNT_W'(1);
        end
      end
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_RUN;
      wsrc_q  <= W_NONE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      pmode_q <= M_RUN;
    end else begin
      mode_q  <= mode_d;
      wsrc_q  <= wsrc_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      pmode_q <= pmode_d;
    end
  end
endmodule

// File: rtl/pmc_clkgen.sv
module pmc_clkgen
  import pmc_pkg::*;
#(
  parameter int NUM_PER   = 4,
  parameter int CODE_W    = 3,
  parameter int NUM_RATES = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  pmode_e             mode_d,
  input  logic [CODE_W-1:0]  rate_code,
  input  logic               rate_load,
  input  logic [NUM_PER-1:0] per_mask,
  input  logic [NUM_PER-1:0] gate_mask,
  output logic               cpu_en_q,
  output logic [NUM_PER-1:0] per_en_q,
  output logic               osc_q
);
  localparam int DIV_W = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

  logic [DIV_W:0]     span;
  logic [DIV_W-1:0]   lim;
  logic [DIV_W-1:0]   div_q;
  logic               run_d;
  logic [NUM_PER-1:0] per_n;

  assign run_d = (mode_d == M_RUN);
  assign span  = {{DIV_W{1'b0}}, 1'b1} << rate_code;
  assign lim   = span[DIV_W-1:0] - DIV_W'(1);

  for (genvar g = 0; g < NUM_PER; g++) begin : g_per
    always_comb begin
      unique case (mode_d)
        M_RUN:   per_n[g] = per_mask[g];
        M_HALT:  per_n[g] = per_mask[g] & ~gate_mask[g];
        default: per_n[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      cpu_en_q <= 1'b0;
      per_en_q <= '0;
      osc_q    <= 1'b1;
    end else begin
      if (rate_load || !run_d || div_q == lim) div_q <= '0;
      else                                     div_q <= div_q + DIV_W'(1);
      cpu_en_q <= run_d && (div_q == '0);
      per_en_q <= per_n;
      osc_q    <= (mode_d != M_STBY);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_PER   = 4,
  parameter int NUM_INT   = 4,
  parameter int CNT_W     = 16,
  parameter int NUM_RATES = 6,
  parameter int SETL_RST  = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               ext_irq,
  input  logic [NUM_INT-1:0] int_irq,
  input  logic               ref_tick,
  output logic               cpu_clk_en,
  output logic [NUM_PER-1:0] per_clk_en,
  output logic               osc_run,
  output logic [1:0]         mode_o,
  output logic [1:0]         wake_src_o
);
  localparam int CODE_W = 3;

  logic [CODE_W-1:0]  rate_code;
  logic               rate_load;
  logic [NUM_PER-1:0] per_mask, gate_mask;
  logic [CNT_W-1:0]   setl_cnt;
  logic               cmd_vld;
  logic [1:0]         cmd_val;
  pmode_e             mode_d, mode_q;
  wsrc_e              wsrc_q;

  pmc_regs #(
    .DATA_W(DATA_W), .NUM_PER(NUM_PER), .CNT_W(CNT_W),
    .CODE_W(CODE_W), .NUM_RATES(NUM_RATES), .SETL_RST(SETL_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate_code(rate_code), .rate_load(rate_load), .per_mask(per_mask),
    .gate_mask(gate_mask), .setl_cnt(setl_cnt), .cmd_vld(cmd_vld), .cmd_val(cmd_val)
  );

  pmc_fsm #(.NUM_INT(NUM_INT), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .int_irq(int_irq), .ref_tick(ref_tick),
    .cmd_vld(cmd_vld), .cmd_val(cmd_val), .setl_cnt(setl_cnt),
    .mode_d(mode_d), .mode_q(mode_q), .wsrc_q(wsrc_q)
  );

  pmc_clkgen #(.NUM_PER(NUM_PER), .CODE_W(CODE_W), .NUM_RATES(NUM_RATES)) u_clk (
    .clk(clk), .rst(rst), .mode_d(mode_d), .rate_code(rate_code), .rate_load(rate_load),
    .per_mask(per_mask), .gate_mask(gate_mask),
    .cpu_en_q(cpu_clk_en), .per_en_q(per_clk_en), .osc_q(osc_run)
  );

  assign mode_o     = mode_q;
  assign wake_src_o = wsrc_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_PER = 4,
  parameter int NUM_INT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               ext_irq,
  input logic [NUM_INT-1:0] int_irq,
  input logic               cpu_clk_en,
  input logic [NUM_PER-1:0] per_clk_en,
  input logic               osc_run,
  input logic [1:0]         mode_o,
  input logic [1:0]         wake_src_o
);
  // R5: light sleep keeps the oscillator but not the CPU clock
  a_r5_halt_cpu_off: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> (!cpu_clk_en && osc_run));

  // R6: any interrupt ends light sleep on the next cycle
  a_r6_halt_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1 && (ext_irq || (|int_irq))) |=> (mode_o == 2'd0));

  // R6: external input wins the wake source
  a_r6_ext_src: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1 && ext_irq) |=> (wake_src_o == 2'd1));

  // R7: deep sleep stops every clock
  a_r7_stby_all_off: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> (!osc_run && !cpu_clk_en && per_clk_en == '0));

  // R7: only the external input leaves deep sleep
  a_r7_stby_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && !ext_irq) |=> (mode_o == 2'd2));

  // R8: external input starts settling, CPU stays off while settling
  a_r8_stby_to_wake: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && ext_irq) |=> (mode_o == 2'd3));

  a_r8_wake_cpu_off: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) |-> (!cpu_clk_en && osc_run));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_PER(NUM_PER), .NUM_INT(NUM_INT)) u_chk (
  .clk(clk), .rst(rst), .ext_irq(ext_irq), .int_irq(int_irq),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
  .mode_o(mode_o), .wake_src_o(wake_src_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int NP = 4;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          ext_irq = 1'b0;
  logic [NI-1:0] int_irq = '0;
  logic          ref_tick = 1'b0;
  logic          cpu_clk_en, osc_run;
  logic [NP-1:0] per_clk_en;
  logic [1:0]    mode_o, wake_src_o;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_irq(ext_irq), .int_irq(int_irq), .ref_tick(ref_tick),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
    .mode_o(mode_o), .wake_src_o(wake_src_o)
  );

  localparam int K_VAL = 0, K_MODE = 1, K_WSRC = 2, K_OSC = 3, K_PER = 4;

  typedef struct {
    string tag;
    int    kind;
    int    exp;
    int    act;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;
  int       checks = 0;
  int       errors = 0;
  bit       done   = 1'b0;

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        sb_item_t it;
        int       got;
        it = sb_q.pop_front();
        case (it.kind)
          K_MODE:  got = int'(mode_o);
          K_WSRC:  got = int'(wake_src_o);
          K_OSC:   got = int'(osc_run);
          K_PER:   got = int'(per_clk_en);
          default: got = it.act;
        endcase
        checks++;
        if (got != it.exp) begin
          errors++;
          $display("FAIL %s: actual %0d expected %0d", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_port(string tag, int kind, int exp);
    sb_item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp; it.act = 0;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic expect_val(string tag, int exp, int act);
    sb_item_t it;
    it.tag = tag; it.kind = K_VAL; it.exp = exp; it.act = act;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic reg_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_irq = 1'b1;
    @(negedge clk); ext_irq = 1'b0;
  endtask

  task automatic pulse_int(int b);
    @(negedge clk); int_irq[b] = 1'b1;
    @(negedge clk); int_irq = '0;
  endtask

  task automatic tick();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu_clk_en) c++;
    end
  endtask

  initial begin
    int c;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    expect_port("R1 mode", K_MODE, 0);
    expect_port("R1 wake source", K_WSRC, 0);
    expect_port("R1 oscillator", K_OSC, 1);
    expect_port("R1 peripherals", K_PER, 4'hF);
    count_pulses(64, c);
    expect_val("R1 divide by one", 64, c);

    // R2 every legal rate
    for (int code = 1; code < 6; code++) begin
      reg_wr(3'd0, 16'(code));
      idle(3);
      count_pulses(64, c);
      expect_val($sformatf("R2 rate code %0d", code), 64 >> code, c);
    end

    // R3 illegal codes leave divide by 8
    reg_wr(3'd0, 16'd3);
    idle(3);
    reg_wr(3'd0, 16'd6);
    idle(3);
    count_pulses(64, c);
    expect_val("R3 code 6 ignored", 8, c);
    reg_wr(3'd0, 16'd7);
    idle(3);
    count_pulses(64, c);
    expect_val("R3 code 7 ignored", 8, c);

    // R4 peripheral mask in RUN
    reg_wr(3'd1, 16'hA);
    idle(2);
    expect_port("R4 mask 1010", K_PER, 4'hA);
    reg_wr(3'd1, 16'h5);
    idle(2);
    expect_port("R4 mask 0101", K_PER, 4'h5);
    reg_wr(3'd1, 16'hE);

    // R5 HALT with gate mask 0010
    reg_wr(3'd2, 16'h2);
    reg_wr(3'd4, 16'd1);
    expect_port("R5 halt mode", K_MODE, 1);
    expect_port("R5 osc runs", K_OSC, 1);
    count_pulses(16, c);
    expect_val("R5 cpu gated", 0, c);
    expect_port("R5 peripherals gated", K_PER, 4'hC);

    // R6 internal interrupt exit
    pulse_int(2);
    expect_port("R6 int exit mode", K_MODE, 0);
    expect_port("R6 int source", K_WSRC, 2);
    reg_wr(3'd4, 16'd1);
    idle(2);
    pulse_ext();
    expect_port("R6 ext exit mode", K_MODE, 0);
    expect_port("R6 ext source", K_WSRC, 1);

    // R7 STANDBY
    reg_wr(3'd0, 16'd0);
    reg_wr(3'd3, 16'd3);
    reg_wr(3'd4, 16'd2);
    expect_port("R7 standby mode", K_MODE, 2);
    expect_port("R7 osc off", K_OSC, 0);
    expect_port("R7 peripherals off", K_PER, 0);
    pulse_int(0);
    idle(2);
    expect_port("R7 int ignored", K_MODE, 2);

    // R8 settling for three ticks
    pulse_ext();
    expect_port("R8 settling mode", K_MODE, 3);
    expect_port("R8 osc restarted", K_OSC, 1);
    count_pulses(8, c);
    expect_val("R8 cpu off while settling", 0, c);
    tick();
    tick();
    expect_port("R8 still settling", K_MODE, 3);
    tick();
    expect_port("R8 run after count", K_MODE, 0);
    expect_port("R8 ext source", K_WSRC, 1);
    idle(2);
    count_pulses(16, c);
    expect_val("R8 cpu resumes", 16, c);

    // R9 zero count acts as one
    reg_wr(3'd3, 16'd0);
    reg_wr(3'd4, 16'd2);
    pulse_ext();
    expect_port("R9 settling", K_MODE, 3);
    tick();
    expect_port("R9 one tick", K_MODE, 0);

    // R10 command held during settling
    reg_wr(3'd3, 16'd2);
    reg_wr(3'd4, 16'd2);
    pulse_ext();
    reg_wr(3'd4, 16'd1);
    idle(2);
    expect_port("R10 held while settling", K_MODE, 3);
    tick();
    tick();
    idle(2);
    expect_port("R10 halt applied", K_MODE, 1);
    pulse_int(1);
    expect_port("R10 left halt", K_MODE, 0);

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule